// File: doc/BRIEF.md
# Input Event Timing Counter

This block is a per-pin timing unit. It counts system clock ticks against events seen on one asynchronous input after that input has been brought into the clock domain. Three event kinds are available: a high level, a low-to-high transition, or a transition in either direction. A held pin reset parks the unit, and releasing the reset starts it.

Two behaviours are selectable. In the elapsed mode, software releases the reset and the unit counts ticks until a programmed number of events has been seen. It then latches the tick count as its result and pulses its flag for one cycle. It stays quiet until the next reset. In the watchdog mode, the result is a live count of ticks since the most recent event, and that count saturates at a ceiling. The flag pulses each time a programmed number of ticks passes with no event.

Top module: `evt_timer`

## Requirements
- R1: While `pinRst` is high the tick counter is held at 1 and `inFlag` is low. `zOut` reads 0 in elapsed mode and 1 in watchdog mode.
- R2: The input passes through a two-flop synchronizer. An input level first sampled by clock edge e after release (edge 1 is the first edge with `pinRst` low) takes part in event detection at edge e+2. Edge detection compares successive synchronized samples. A level already present during reset counts as the sample before edge 1.
- R3: In elapsed mode, `inFlag` rises for exactly one cycle per release. After the capture, `zOut` holds its value and no further flag is raised until `pinRst` is reapplied.
- R4: In elapsed mode, `zOut` becomes the number of the clock edge after release at which the N-th event is detected, where N = `xParam`. The flag is raised by that same edge.
- R5: `cfgSel[2]` = 1 selects watchdog mode and 0 selects elapsed mode. `cfgSel[1:0]` picks the event kind: 00 high level, 01 rising transition, 10 any transition, 11 high level.
- R6: In watchdog mode, `inFlag` pulses for one cycle after each run of `xParam` consecutive ticks with no event, and a new window then begins.
- R7: In watchdog mode, `zOut` shows the ticks since the latest event. It increases by one per edge. An event loads it to 1 and restarts the timeout window without raising the flag.
- R8: The tick count saturates at the ceiling `SAT_CAP` (default 0x8000_0000) and stays there until an event or a reset.
- R9: An `xParam` of 0 behaves as 1.
- R10: In elapsed mode, `zOut` reads 0 after release until the capture happens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| pinRst | input | 1 | Pin reset; high holds the unit parked, low lets it run |
| sigIn | input | 1 | Asynchronous input being timed |
| xParam | input | 32 | Event count (elapsed mode) or timeout length in ticks (watchdog mode) |
| cfgSel | input | 3 | Bit 2 selects the mode, bits 1:0 select the event kind |
| zOut | output | 32 | Captured elapsed time, or the live tick count since the last event |
| inFlag | output | 1 | One-cycle flag for a capture or a timeout |

## Verification
The embedded properties assume that `cfgSel` and `xParam` change only while `pinRst` is high. A mode switch in mid-run would leave the event and window counters holding values from the other mode. The stimulus therefore programs both fields only inside a reset phase, and holds reset for several cycles with the input at its starting level so that the synchronizer holds defined values before release. The ceiling is lowered by a parameter in the bench so that saturation can be reached in a short run.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  typedef enum logic [1:0] {
    KIND_HIGH     = 2'b00,
    KIND_RISE     = 2'b01,
    KIND_EDGE     = 2'b10,
    KIND_HIGH_ALT = 2'b11
  } evtKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic tickLoadOne;
    logic tickAdvance;
    logic zCapture;
    logic flagPulse;
  } dpStrobe_t;

endpackage

// File: rtl/evt_timer_sync.sv
module evt_timer_sync
  import evt_timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     pinIn,
  input  evtKind_e kindSel,
  output logic     evtHit
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] shQ;
  logic          prevQ;
  logic          lvl;

  generate
    if (SYNC_STAGES < 2) begin : g_bad
      initial $error("SYNC_STAGES must be at least 2");
    end
  endgenerate

  always_ff @(posedge clk) begin
    shQ   <= {shQ[LAST-1:0], pinIn};
    prevQ <= shQ[LAST];
  end

  assign lvl = shQ[LAST];

  always_comb begin
    unique case (kindSel)
      KIND_RISE: evtHit = lvl & ~prevQ;
      KIND_EDGE: evtHit = lvl ^ prevQ;
      default:   evtHit = lvl;
    endcase
  end

endmodule

// File: rtl/evt_timer_ctrl.sv
module evt_timer_ctrl
  import evt_timer_pkg::*;
#(
  parameter int XW = 32
) (
  input  logic          clk,
  input  logic          rstHeld,
  input  logic          timeoutMode,
  input  logic [XW-1:0] xLimit,
  input  logic          evtHit,
  output dpStrobe_t     strobe
);

  localparam logic [XW-1:0] ONE_X = XW'(1);

  logic [XW-1:0] xEff;
  logic [XW-1:0] evtCntQ;
  logic [XW-1:0] winCntQ;
  logic          doneQ;
  logic          lastEvt;
  logic          winEnd;

  assign xEff    = (xLimit == '0) ? ONE_X : xLimit;
  assign lastEvt = evtHit && ((evtCntQ + ONE_X) == xEff);
  assign winEnd  = (winCntQ + ONE_X) == xEff;

  always_comb begin
    strobe = '0;
    if (rstHeld) begin
      strobe.tickLoadOne = 1'b1;
    end else if (timeoutMode) begin
      if (evtHit) begin
        strobe.tickLoadOne = 1'b1;
      end else begin
        strobe.tickAdvance = 1'b1;
        strobe.flagPulse   = winEnd;
      end
    end else if (!doneQ) begin
      if (lastEvt) begin
        strobe.zCapture  = 1'b1;
        strobe.flagPulse = 1'b1;
      end else begin
        strobe.tickAdvance = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rstHeld) begin
      evtCntQ <= '0;
      winCntQ <= '0;
      doneQ   <= 1'b0;
    end else if (timeoutMode) begin
      if (evtHit || winEnd) winCntQ <= '0;
      else                  winCntQ <= winCntQ + ONE_X;
    end else if (!doneQ) begin
      if (lastEvt)     doneQ   <= 1'b1;
      else if (evtHit) evtCntQ <= evtCntQ + ONE_X;
    end
  end

  // R6: timeout window counter never reaches the programmed length
  p_win_bound_r6: assert property (@(posedge clk) disable iff (rstHeld)
    timeoutMode |-> (winCntQ < xEff));

  // R4: events counted so far stay below the target until capture
  p_evt_bound_r4: assert property (@(posedge clk) disable iff (rstHeld)
    !timeoutMode |-> (evtCntQ < xEff));

  // R3: once captured, no more strobes until reset
  p_idle_after_done_r3: assert property (@(posedge clk) disable iff (rstHeld)
    (!timeoutMode && doneQ) |-> (strobe == '0));

endmodule

// File: rtl/evt_timer_dp.sv
module evt_timer_dp
  import evt_timer_pkg::*;
#(
  parameter int               CNT_W   = 32,
  parameter logic [CNT_W-1:0] SAT_CAP = {1'b1, {(CNT_W-1){1'b0}}}
) (
  input  logic             clk,
  input  logic             rstHeld,
  input  logic             timeoutMode,
  input  dpStrobe_t        strobe,
  output logic [CNT_W-1:0] zOut,
  output logic             inFlag
);

  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  logic [CNT_W-1:0] tickQ;
  logic [CNT_W-1:0] tickSat;
  logic [CNT_W-1:0] zCapQ;
  logic             flagQ;

  assign tickSat = (tickQ >= SAT_CAP) ? SAT_CAP : (tickQ + ONE_C);

  always_ff @(posedge clk) begin
    if (strobe.tickLoadOne)      tickQ <= ONE_C;
    else if (strobe.tickAdvance) tickQ <= tickSat;
  end

  always_ff @(posedge clk) begin
    if (rstHeld)              zCapQ <= '0;
    else if (strobe.zCapture) zCapQ <= tickQ;
  end

  always_ff @(posedge clk) begin
    flagQ <= strobe.flagPulse;
  end

  assign zOut   = timeoutMode ? tickQ : zCapQ;
  assign inFlag = flagQ;

  // R1: reset parks the tick counter at one
  p_hold_one_r1: assert property (@(posedge clk)
    rstHeld |=> (tickQ == ONE_C));

  // R3: elapsed-mode flag lasts a single cycle
  p_flag_single_r3: assert property (@(posedge clk) disable iff (rstHeld)
    (!timeoutMode && flagQ) |=> !flagQ);

  // R3: captured value holds after the capture
  p_zcap_hold_r3: assert property (@(posedge clk) disable iff (rstHeld)
    (!timeoutMode && flagQ) |=> $stable(zCapQ));

  // R8: tick count never passes the ceiling
  p_sat_cap_r8: assert property (@(posedge clk) disable iff (rstHeld)
    tickQ <= SAT_CAP);

  // R8: once saturated, it stays saturated while only advancing
  p_sat_stay_r8: assert property (@(posedge clk) disable iff (rstHeld)
    (tickQ == SAT_CAP && strobe.tickAdvance) |=> (tickQ == SAT_CAP));

  // R7: an event in watchdog mode reloads one and raises no flag
  p_evt_reload_r7: assert property (@(posedge clk) disable iff (rstHeld)
    (timeoutMode && strobe.tickLoadOne) |=> (tickQ == ONE_C && !flagQ));

endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int               CNT_W   = 32,
  parameter int               XW      = 32,
  parameter int               SYNC_STAGES = 2,
  parameter logic [CNT_W-1:0] SAT_CAP = {1'b1, {(CNT_W-1){1'b0}}}
) (
  input  logic             clk,
  input  logic             pinRst,
  input  logic             sigIn,
  input  logic [XW-1:0]    xParam,
  input  logic [2:0]       cfgSel,
  output logic [CNT_W-1:0] zOut,
  output logic             inFlag
);

  logic      evtHit;
  logic      timeoutMode;
  evtKind_e  kindSel;
  dpStrobe_t strobe;

  assign timeoutMode = cfgSel[2];
  assign kindSel     = evtKind_e'(cfgSel[1:0]);

  evt_timer_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .pinIn   (sigIn),
    .kindSel (kindSel),
    .evtHit  (evtHit)
  );

  evt_timer_ctrl #(.XW(XW)) u_ctrl (
    .clk         (clk),
    .rstHeld     (pinRst),
    .timeoutMode (timeoutMode),
    .xLimit      (xParam),
    .evtHit      (evtHit),
    .strobe      (strobe)
  );

  evt_timer_dp #(.CNT_W(CNT_W), .SAT_CAP(SAT_CAP)) u_dp (
    .clk         (clk),
    .rstHeld     (pinRst),
    .timeoutMode (timeoutMode),
    .strobe      (strobe),
    .zOut        (zOut),
    .inFlag      (inFlag)
  );

endmodule

// File: tb/evt_timer_tb.sv
`timescale 1ns/1ps
module evt_timer_tb;

  localparam logic [31:0] TB_CAP = 32'd300;

  logic        clk = 1'b0;
  logic        pinRst = 1'b1;
  logic        sigIn = 1'b0;
  logic [31:0] xParam = 32'd1;
  logic [2:0]  cfgSel = 3'b000;
  logic [31:0] zOut;
  logic        inFlag;

  int compared = 0;
  int mismatched = 0;
  bit summaryDone = 1'b0;

  always #4 clk = ~clk;

  evt_timer #(.SAT_CAP(TB_CAP)) u_dut (
    .clk    (clk),
    .pinRst (pinRst),
    .sigIn  (sigIn),
    .xParam (xParam),
    .cfgSel (cfgSel),
    .zOut   (zOut),
    .inFlag (inFlag)
  );

  typedef struct packed {
    logic [2:0]  cfg;
    logic [31:0] x;
    logic        init;
    int          start;
    int          len;
    int          per;
    int          np;
    int          expZ;
  } vec_t;

  // elapsed-mode vectors: pulse train after release, expected capture edge
  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{3'b001, 32'd1, 1'b0,  5, 2, 4, 3,  7},  // R4 rise, first
    '{3'b001, 32'd3, 1'b0,  5, 2, 4, 3, 15},  // R4 third rise
    '{3'b000, 32'd3, 1'b0,  5, 2, 4, 3, 11},  // R5 high level, third high sample
    '{3'b010, 32'd3, 1'b0,  5, 2, 4, 3, 11},  // R5 any edge, third edge
    '{3'b010, 32'd4, 1'b0,  5, 2, 4, 3, 13},  // R5 any edge, includes fall
    '{3'b000, 32'd1, 1'b1, 20, 2, 4, 1,  1},  // R2 high during reset
    '{3'b001, 32'd1, 1'b1, 20, 2, 4, 2, 26},  // R2 level high at release is no rise
    '{3'b011, 32'd1, 1'b0,  8, 2, 4, 1, 10},  // R5 code 11 acts as high
    '{3'b001, 32'd0, 1'b0,  6, 2, 4, 1,  8},  // R9 zero treated as one
    '{3'b010, 32'd1, 1'b1, 10, 2, 4, 1, 14}   // R5 falling edge counts
  };

  function automatic logic pat(vec_t v, int e);
    int k;
    if (e < v.start) return v.init;
    k = e - v.start;
    if ((k / v.per) >= v.np) return 1'b0;
    return ((k % v.per) < v.len);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic [2:0] cfg, input logic [31:0] x, input logic init);
    @(negedge clk);
    pinRst = 1'b1;
    cfgSel = cfg;
    xParam = x;
    sigIn  = init;
    repeat (4) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    if (!summaryDone) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finishRun();
    end
  end

  initial begin
    int flags;
    int flagEdge;

    // vector table, elapsed mode
    for (int r = 0; r < NVEC; r++) begin
      doReset(VECS[r].cfg, VECS[r].x, VECS[r].init);
      chk("R1 elapsed reset zOut", zOut, 32'd0);
      chk("R1 reset flag", {31'd0, inFlag}, 32'd0);
      flags = 0;
      flagEdge = 0;
      for (int e = 1; e <= 60; e++) begin
        pinRst = 1'b0;
        sigIn  = pat(VECS[r], e);
        @(negedge clk);
        if (inFlag) begin
          flags++;
          flagEdge = e;
        end
        if (e == 1 && VECS[r].expZ > 1)
          chk("R10 zOut before capture", zOut, 32'd0);
      end
      chk("R3 one flag per release", flags, 32'd1);
      chk("R4 captured zOut", zOut, VECS[r].expZ);
      chk("R2 capture edge", flagEdge, VECS[r].expZ);
    end

    // R6 R7: watchdog, no events, X=5
    doReset(3'b101, 32'd5, 1'b0);
    chk("R1 watchdog reset zOut", zOut, 32'd1);
    flags = 0;
    for (int e = 1; e <= 20; e++) begin
      pinRst = 1'b0;
      sigIn  = 1'b0;
      @(negedge clk);
      if (inFlag) flags++;
      if (e == 4)  chk("R6 no flag before window end", {31'd0, inFlag}, 32'd0);
      if (e == 5)  chk("R6 flag at window end", {31'd0, inFlag}, 32'd1);
      if (e == 12) chk("R7 running count", zOut, 32'd13);
    end
    chk("R6 flag count", flags, 32'd4);

    // R7: event restarts window and loads one
    doReset(3'b101, 32'd5, 1'b0);
    flags = 0;
    for (int e = 1; e <= 16; e++) begin
      pinRst = 1'b0;
      sigIn  = (e >= 8);
      @(negedge clk);
      if (inFlag) flags++;
      if (e == 5)  chk("R6 first timeout", {31'd0, inFlag}, 32'd1);
      if (e == 10) chk("R7 event loads one", zOut, 32'd1);
      if (e == 10) chk("R7 event suppresses flag", {31'd0, inFlag}, 32'd0);
      if (e == 13) chk("R7 count after event", zOut, 32'd4);
      if (e == 15) chk("R7 window restarted", {31'd0, inFlag}, 32'd1);
    end
    chk("R7 flag count", flags, 32'd2);

    // R8: saturation at ceiling
    doReset(3'b100, 32'd1000, 1'b0);
    for (int e = 1; e <= 350; e++) begin
      pinRst = 1'b0;
      sigIn  = 1'b0;
      @(negedge clk);
      if (e == 298) chk("R8 below ceiling", zOut, 32'd299);
      if (e == 299) chk("R8 reaches ceiling", zOut, TB_CAP);
      if (e == 350) chk("R8 stays at ceiling", zOut, TB_CAP);
    end

    // R9: X=0 in watchdog mode flags every tick
    doReset(3'b101, 32'd0, 1'b0);
    flags = 0;
    for (int e = 1; e <= 10; e++) begin
      pinRst = 1'b0;
      @(negedge clk);
      if (inFlag) flags++;
    end
    chk("R9 zero window acts as one", flags, 32'd10);

    // R5 R7: high-level kind held high keeps count at one, no timeouts
    doReset(3'b100, 32'd3, 1'b1);
    flags = 0;
    for (int e = 1; e <= 12; e++) begin
      pinRst = 1'b0;
      sigIn  = 1'b1;
      @(negedge clk);
      if (inFlag) flags++;
    end
    chk("R7 continuous events hold one", zOut, 32'd1);
    chk("R5 high kind no timeout", flags, 32'd0);

    finishRun();
  end

endmodule